// File: doc/BRIEF.md
# Control-Word Driven Register Datapath

This block is a single-cycle datapath steered entirely by a 16-bit control word. It holds eight general registers of a parameterised width, reads two of them at once, passes one operand (or an externally supplied constant) through a shared function unit, and writes either the function result or an external data word back into one register on the rising clock edge. Exactly one microoperation completes per clock.

The register selected as the left operand is driven straight out as an address, and the right operand bus is driven out as write data. A caller can therefore present an address and data for a memory or output write without changing any register, by clearing the write bit. Four status flags (overflow, carry, negative, zero) are registered from the function result on every clock. Sequencing, instruction fetch and memory are outside the block. The caller applies one control word per cycle and supplies the data input directly.

Top module: `cw_datapath`

## Requirements
- R1: A synchronous active-high reset clears all eight registers and all four status flags to zero. Register writes are suppressed while reset is high.
- R2: Control word bits [12:10] select the register read onto the left operand bus. That bus appears combinationally on `addr_out`.
- R3: Control word bit [6] selects the right operand bus. 0 selects the register addressed by bits [9:7], and 1 selects `const_in`. The bus appears combinationally on `data_out`.
- R4: When bit [0] is 1, the register addressed by bits [15:13] loads the destination bus on the rising edge. When bit [0] is 0, no register changes.
- R5: Control word bit [1] selects the destination bus. 0 selects the function result, and 1 selects `data_in`.
- R6: Function codes in bits [5:2] 0000 to 0111 are arithmetic. The right operand is modified by code bits [2:1] (00 zero, 01 B, 10 inverted B, 11 all ones), and code bit [0] is the carry-in. This gives A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A.
- R7: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A respectively.
- R8: Codes 1100 and 1111 pass B. Code 1101 shifts B right by one, and code 1110 shifts B left by one, both with zero fill.
- R9: On each rising edge, the flags capture the function result of that cycle. Z is set when the result is all zero, and N is the result's top bit. For arithmetic codes, C is the adder carry-out and V is signed overflow. For all other codes, C and V are 0.
- R10: A register that is both read and written in one cycle shows its old value on the operand buses until the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word for the current microoperation |
| const_in | input | W | Constant operand for the right bus |
| data_in | input | W | External data for the destination bus |
| addr_out | output | W | Left operand bus |
| data_out | output | W | Right operand bus |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry-out flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
A wrong register content stays hidden until that register is selected as an operand. The bench therefore reads back every register through `addr_out` after every clock, so a misdirected or missing write shows within the same cycle. A wrong function code mapping or flag rule appears on the flag outputs one edge after the control word is applied. The bench also sees it when the stored result is read back. The sweep runs every function code against operand pairs chosen to cross the sign and carry boundaries.

// File: rtl/cwdp_pkg.sv
`timescale 1ns/1ps
package cwdp_pkg;
  localparam int CW_W   = 16;
  localparam int ADDR_W = 3;
  localparam int NREG   = 1 << ADDR_W;
  localparam int FS_W   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src_a;
    logic [ADDR_W-1:0] src_b;
    logic              b_const;
    logic [FS_W-1:0]   func;
    logic              d_ext;
    logic              wr;
  } ctrl_t;
endpackage

// File: rtl/cwdp_regfile.sv
`timescale 1ns/1ps
module cwdp_regfile #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  // asynchronous reads: old contents visible until the write edge
  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/cwdp_arith.sv
`timescale 1ns/1ps
module cwdp_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] y;
  logic [W:0]   wide;

  always_comb begin
    unique case (sel[2:1])
      2'b00:   y = '0;
      2'b01:   y = b;
      2'b10:   y = ~b;
      default: y = '1;
    endcase
  end

  assign wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, sel[0]};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (a[W-1] == y[W-1]) && (wide[W-1] != a[W-1]);
endmodule

// File: rtl/cwdp_logic_shift.sv
`timescale 1ns/1ps
module cwdp_logic_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (sel)
      3'b000:  res = a & b;
      3'b001:  res = a | b;
      3'b010:  res = a ^ b;
      3'b011:  res = ~a;
      3'b101:  res = {1'b0, b[W-1:1]};
      3'b110:  res = {b[W-2:0], 1'b0};
      default: res = b;
    endcase
  end
endmodule

// File: rtl/cwdp_func_unit.sv
`timescale 1ns/1ps
module cwdp_func_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fs,
  output logic [W-1:0] f,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] ar_sum, ls_res;
  logic         ar_c, ar_v;

  cwdp_arith #(.W(W)) u_arith (
    .a(a), .b(b), .sel(fs[2:0]), .sum(ar_sum), .cout(ar_c), .ovf(ar_v)
  );

  cwdp_logic_shift #(.W(W)) u_ls (
    .a(a), .b(b), .sel(fs[2:0]), .res(ls_res)
  );

  assign f    = fs[3] ? ls_res : ar_sum;
  assign cout = !fs[3] && ar_c;
  assign ovf  = !fs[3] && ar_v;
endmodule

// File: rtl/cw_datapath.sv
`timescale 1ns/1ps
module cw_datapath #(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [cwdp_pkg::CW_W-1:0] ctrl_word,
  input  logic [W-1:0]             const_in,
  input  logic [W-1:0]             data_in,
  output logic [W-1:0]             addr_out,
  output logic [W-1:0]             data_out,
  output logic                     flag_v,
  output logic                     flag_c,
  output logic                     flag_n,
  output logic                     flag_z
);
  import cwdp_pkg::*;

  ctrl_t        cw;
  logic [W-1:0] rd_a, rd_b, bus_b, bus_d, fu_f;
  logic         fu_c, fu_v;

  assign cw = ctrl_t'(ctrl_word);

  cwdp_regfile #(.W(W), .AW(ADDR_W)) u_rf (
    .clk(clk), .rst(rst), .we(cw.wr), .wa(cw.dst), .wd(bus_d),
    .ra_a(cw.src_a), .ra_b(cw.src_b), .rd_a(rd_a), .rd_b(rd_b)
  );

  assign bus_b = cw.b_const ? const_in : rd_b;

  cwdp_func_unit #(.W(W)) u_fu (
    .a(rd_a), .b(bus_b), .fs(cw.func), .f(fu_f), .cout(fu_c), .ovf(fu_v)
  );

  assign bus_d    = cw.d_ext ? data_in : fu_f;
  assign addr_out = rd_a;
  assign data_out = bus_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_v <= 1'b0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_v <= fu_v;
      flag_c <= fu_c;
      flag_n <= fu_f[W-1];
      flag_z <= (fu_f == '0);
    end
  end
endmodule

// File: rtl/cw_datapath_chk.sv
`timescale 1ns/1ps
module cw_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr,
  input logic [2:0]   dst,
  input logic [2:0]   src_a,
  input logic         logic_op,
  input logic [W-1:0] addr_out,
  input logic [W-1:0] bus_d,
  input logic         flag_v,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_z
);
  // R1: flags are clear on the first cycle after reset
  a_r1_flags_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !flag_v && !flag_c && !flag_n && !flag_z);

  // R4: no write means a re-read register is unchanged
  a_r4_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr) && src_a == $past(src_a)) |-> $stable(addr_out));

  // R4: a written register reads back the destination bus value
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr) && src_a == $past(dst)) |-> addr_out == $past(bus_d));

  // R9: logic and shift codes leave carry and overflow clear
  a_r9_logic_cv_clear: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(logic_op)) |-> !flag_c && !flag_v);

  // R9: a zero result cannot be negative
  a_r9_zero_not_neg: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> !flag_n);
endmodule

bind cw_datapath cw_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr(cw.wr), .dst(cw.dst), .src_a(cw.src_a),
  .logic_op(cw.func[3]), .addr_out(addr_out), .bus_d(bus_d),
  .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/tb_cw_datapath.sv
`timescale 1ns/1ps
module tb_cw_datapath;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  ctrl_word = '0;
  logic [W-1:0] const_in = '0, data_in = '0;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int total = 0, bad = 0;
  logic [W-1:0] model [8];
  logic mv, mc, mn, mz;

  always #5 clk = ~clk;

  cw_datapath #(.W(W)) dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic logic [15:0] mk(input int d, input int a, input int b,
      input bit mb, input int fs, input bit md, input bit rw);
    return {d[2:0], a[2:0], b[2:0], mb, fs[3:0], md, rw};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input logic [W-1:0] x);
    return x[W-1] ? int'(x) - (1 << W) : int'(x);
  endfunction

  task automatic ref_fu(input logic [3:0] fs, input logic [W-1:0] a, b,
      output logic [W-1:0] f, output logic c, output logic v);
    logic [W-1:0] y;
    int u, s, cin;
    c = 0; v = 0;
    if (!fs[3]) begin
      cin = fs[0];
      case (fs[2:1])
        2'd0: y = 0;
        2'd1: y = b;
        2'd2: y = ~b;
        default: y = {W{1'b1}};
      endcase
      u = int'(a) + int'(y) + cin;
      f = u[W-1:0];
      c = u >= (1 << W);
      s = sgn(a) + sgn(y) + cin;
      v = (s > (1 << (W-1)) - 1) || (s < -(1 << (W-1)));
    end else begin
      case (fs)
        4'd8:  f = a & b;
        4'd9:  f = a | b;
        4'd10: f = a ^ b;
        4'd11: f = ~a;
        4'd13: f = b >> 1;
        4'd14: f = b << 1;
        default: f = b;
      endcase
    end
  endtask

  task automatic step(input logic [15:0] w, input logic [W-1:0] k, d);
    logic [W-1:0] ea, eb, f, bd;
    logic c, v;
    @(negedge clk);
    ctrl_word = w; const_in = k; data_in = d;
    #1;
    ea = model[w[12:10]];
    eb = w[6] ? k : model[w[9:7]];
    chk("R2 addr_out", addr_out, ea);
    chk("R3 data_out", data_out, eb);
    if (w[0] && w[15:13] == w[12:10])
      chk("R10 old value before edge", addr_out, ea);
    ref_fu(w[5:2], ea, eb, f, c, v);
    bd = w[1] ? d : f;
    @(posedge clk);
    if (w[0]) model[w[15:13]] = bd;
    mv = v; mc = c; mn = f[W-1]; mz = (f == 0);
    #1;
    chk("R9 flag_z", flag_z, mz);
    chk("R9 flag_n", flag_n, mn);
    chk(w[5] ? "R9 flag_c R7 R8" : "R9 flag_c R6", flag_c, mc);
    chk("R9 flag_v", flag_v, mv);
    for (int r = 0; r < 8; r++) begin
      ctrl_word = mk(0, r, 0, 0, 0, 0, 0);
      #0.4;
      chk(w[1] ? "R5 R4 register" : "R4 R6 R7 R8 register", addr_out, model[r]);
    end
  endtask

  logic [W-1:0] pats [8];

  initial begin
    pats = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff, 8'h55, 8'haa, 8'h3c};
    for (int r = 0; r < 8; r++) model[r] = 0;
    // drive a write during reset: it must be suppressed (R1)
    ctrl_word = mk(3, 0, 0, 1, 12, 0, 1); const_in = 8'h99;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ctrl_word = '0;
    #1;
    chk("R1 flag_v", flag_v, 0);
    chk("R1 flag_c", flag_c, 0);
    chk("R1 flag_n", flag_n, 0);
    chk("R1 flag_z", flag_z, 0);
    for (int r = 0; r < 8; r++) begin
      ctrl_word = mk(0, r, 0, 0, 0, 0, 0);
      #0.4;
      chk("R1 register clear", addr_out, 0);
    end

    // constant loads via pass-B (R3, R4, R8)
    for (int r = 0; r < 8; r++) step(mk(r, 0, 0, 1, 12, 0, 1), W'(r * 37 + 5), 8'h00);
    // external data loads (R5)
    step(mk(1, 2, 3, 0, 2, 1, 1), 8'h00, 8'hc3);
    step(mk(3, 1, 1, 1, 9, 1, 1), 8'h11, 8'h00);
    // write blocked: memory-write style cycle (R4)
    step(mk(5, 4, 2, 0, 2, 1, 0), 8'hee, 8'h77);
    step(mk(0, 6, 7, 1, 12, 0, 0), 8'h5a, 8'h00);
    // read and write same register (R10)
    step(mk(2, 2, 2, 0, 1, 0, 1), 8'h00, 8'h00);
    step(mk(4, 4, 1, 0, 5, 0, 1), 8'h00, 8'h00);

    // sweep every function code over sign and carry boundary operands
    for (int p = 0; p < 8; p++) begin
      step(mk(6, 0, 0, 1, 12, 0, 1), pats[p], 8'h00);
      step(mk(7, 0, 0, 1, 12, 0, 1), pats[(p * 3 + 1) % 8], 8'h00);
      for (int fs = 0; fs < 16; fs++)
        step(mk(fs % 6, 6, 7, 0, fs, 0, 1), 8'h00, 8'h00);
      for (int fs = 0; fs < 16; fs += 3)
        step(mk((fs + p) % 6, 6, 0, 1, fs, 0, 1), pats[(p + 5) % 8], 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule